// File: doc/BRIEF.md
# Interrupt Request Latch and Instruction-Boundary Poller

This block collects interrupt requests for a CPU core whose instructions take one to four clock cycles. It decides, at each instruction boundary, whether to redirect execution. Two active-low external pins are sampled on every clock. Each pin can be set to level sensing or to falling-edge sensing. Five peripheral request strobes are latched into sticky flags: three timers, a serial port and SPI. The SPI request has a vector of its own, separate from the serial port.

The core reports two per-cycle status bits: one marks the final cycle of the current instruction, the other marks the cycle just before it. The block snapshots the pending flags at the end of each such cycle. The final-cycle decision uses only that snapshot, so a request that arrives late in an instruction waits for the next boundary. When the snapshot qualifies an enabled request, the block issues a one-cycle take pulse together with a vector index. It also clears the latched flag of the source it has acknowledged.

Top module: `irq_poll_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, `irq_take` is 0 and `irq_vec` is 0. No request is pending after reset.
- R2: Each external pin is sampled on every clock. In level mode (`extN_edge`=0), a request is pending while the sampled pin is low, and is gone once a high sample is taken.
- R3: In edge mode (`extN_edge`=1), a high sample followed by a low sample on the next clock sets a flag. This holds even for a low pulse only one cycle wide. The flag stays set until its interrupt is taken and is then cleared, even if the pin stays low.
- R4: A one-cycle pulse on a peripheral strobe sets a flag that stays set until that source is taken.
- R5: Requests are polled only in a cycle with `last_cyc`=1. The take pulse and vector appear in the cycle after that cycle and last exactly one cycle, whatever the instruction length (1 to 4 cycles).
- R6: A request qualifies at a boundary only if it was pending during the cycle marked `penult_cyc`. A request that first becomes pending in that cycle or later is not taken at that boundary.
- R7: For a one-cycle instruction (`last_cyc` with no `penult_cyc` before it), a request qualifies only if it was pending during the previous instruction's last cycle.
- R8: Among several qualified and enabled requests, the lowest vector index wins. Vector indices are ext0=0, timer0=1, ext1=2, timer1=3, serial=4, timer2=5, SPI=6.
- R9: `ie_main` bit 7 gates every request. `ie_main` bits 0..5 enable vector indices 0..5 one for one, and `ie_aux` bit 2 enables SPI. A latched request that is disabled is not lost: it is taken once it is enabled.
- R10: SPI and serial requests are distinct sources with distinct vectors (6 and 4), each with its own enable.
- R11: No interrupt is taken in the cycle in which a take pulse is being presented, even if `last_cyc` is 1 in that cycle. Requests pending then are taken at a later boundary.
- R12: Taking a level-sensed external interrupt does not clear it. While its pin stays low it is taken again at the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext0_n | input | 1 | External request pin 0, active low |
| ext1_n | input | 1 | External request pin 1, active low |
| ext0_edge | input | 1 | Pin 0 sensing: 1 falling edge, 0 level |
| ext1_edge | input | 1 | Pin 1 sensing: 1 falling edge, 0 level |
| tmr0_evt | input | 1 | Timer 0 request strobe |
| tmr1_evt | input | 1 | Timer 1 request strobe |
| tmr2_evt | input | 1 | Timer 2 request strobe |
| uart_evt | input | 1 | Serial port request strobe |
| spi_evt | input | 1 | SPI request strobe |
| ie_main | input | 8 | Global enable (bit 7) and enables for vectors 0..5 (bits 0..5) |
| ie_aux | input | 8 | Secondary enables; bit 2 enables SPI |
| last_cyc | input | 1 | Core is in the final cycle of an instruction |
| penult_cyc | input | 1 | Core is in the cycle before the final one |
| irq_take | output | 1 | One-cycle interrupt-take pulse |
| irq_vec | output | 3 | Vector index of the taken interrupt |

## Verification
A strobe becomes a flag at the first clock edge. A pin level becomes a level request one edge later, and an edge flag two edges after the pin falls. These sit inside the idle cycles the bench inserts before each instruction. The poll snapshot is taken at the edge that closes the `penult_cyc` or `last_cyc` cycle. `irq_take`/`irq_vec` become valid right after the edge that closes the `last_cyc` cycle and fall one edge later. The bench drives every input on the falling clock edge and reads the outputs at the falling edge that follows the closing edge of the last cycle. It reads the dropped take pulse one falling edge after that, so each comparison lands in the single cycle where the result is due.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;

    localparam int unsigned SRC_N         = 7;
    localparam int unsigned VEC_W         = $clog2(SRC_N);
    localparam int unsigned IE_W          = 8;
    localparam int unsigned IE_GLOBAL_BIT = 7;
    localparam int unsigned IE2_SPI_BIT   = 2;
    localparam int unsigned EXT_N         = 2;

    // Vector index doubles as priority rank: lower value wins.
    typedef enum logic [VEC_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_UART = 3'd4,
        SRC_TMR2 = 3'd5,
        SRC_SPI  = 3'd6
    } src_e;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef struct packed {
        logic hit;
        src_e idx;
    } pick_t;

    // Sources held in sticky flags inside the latch bank; the external
    // pins are conditioned by their own sensing logic and pass straight through.
    localparam src_vec_t LATCHED_SRC = 7'b111_1010;

    function automatic pick_t pick_first(input src_vec_t req);
        pick_t r;
        r.hit = 1'b0;
        r.idx = SRC_EXT0;
        for (int i = int'(SRC_N) - 1; i >= 0; i--) begin
            if (req[i]) begin
                r.hit = 1'b1;
                r.idx = src_e'(i[VEC_W-1:0]);
            end
        end
        return r;
    endfunction

    function automatic src_vec_t onehot_of(input src_e s);
        src_vec_t r;
        r = '0;
        r[s] = 1'b1;
        return r;
    endfunction

    function automatic src_vec_t build_enables(input logic [IE_W-1:0] main_r,
                                               input logic [IE_W-1:0] aux_r);
        src_vec_t r;
        r           = '0;
        r[SRC_EXT0] = main_r[0];
        r[SRC_TMR0] = main_r[1];
        r[SRC_EXT1] = main_r[2];
        r[SRC_TMR1] = main_r[3];
        r[SRC_UART] = main_r[4];
        r[SRC_TMR2] = main_r[5];
        r[SRC_SPI]  = aux_r[IE2_SPI_BIT];
        return r;
    endfunction

endpackage

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic ack,
    output logic req
);

    logic samp_q;
    logic prev_q;
    logic flag_q;
    logic fall;

    // Pin idles high; both sample stages reset to the idle level.
    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            samp_q <= pin_n;
            prev_q <= samp_q;
        end
    end

    assign fall = prev_q & ~samp_q;

    always_ff @(posedge clk) begin
        if (rst || !edge_mode) begin
            flag_q <= 1'b0;
        end else if (fall) begin
            flag_q <= 1'b1;
        end else if (ack) begin
            flag_q <= 1'b0;
        end
    end

    assign req = edge_mode ? flag_q : ~samp_q;

    // R3
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && fall) |=> flag_q);

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && flag_q && !ack) |=> flag_q);

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
    import irq_poll_pkg::*;
#(
    parameter int unsigned N     = SRC_N,
    parameter logic [N-1:0] LATCH = LATCHED_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] ack_vec,
    output logic [N-1:0] pend
);

    for (genvar g = 0; g < int'(N); g++) begin : g_src
        if (LATCH[g]) begin : g_sticky
            logic flag_q;
            // A new strobe wins over an acknowledge in the same cycle.
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_q <= 1'b0;
                end else if (raw[g]) begin
                    flag_q <= 1'b1;
                end else if (ack_vec[g]) begin
                    flag_q <= 1'b0;
                end
            end
            assign pend[g] = flag_q;

            // R4
            strobe_latch_chk: assert property (@(posedge clk) disable iff (rst)
                raw[g] |=> pend[g]);
        end else begin : g_thru
            logic unused_ack;
            assign unused_ack = ack_vec[g];
            assign pend[g]    = raw[g];
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_poll_pkg::*;
(
    input  src_vec_t req,
    output pick_t    pick
);

    assign pick = pick_first(req);

endmodule

// File: rtl/irq_poll_core.sv
module irq_poll_core
    import irq_poll_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t pend,
    input  src_vec_t en_vec,
    input  logic     gie,
    input  logic     last,
    input  logic     penult,
    output logic     take,
    output src_e     vec,
    output src_vec_t ack_vec
);

    src_vec_t snap_q;
    src_vec_t cand;
    logic     take_q;
    src_e     vec_q;
    pick_t    pk;
    logic     grant;

    assign cand = snap_q & en_vec & {SRC_N{gie}};

    irq_prio_pick u_pick (
        .req  (cand),
        .pick (pk)
    );

    // The acknowledge cycle itself never grants.
    assign grant   = last & ~take_q & pk.hit;
    assign ack_vec = grant ? onehot_of(pk.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            take_q <= 1'b0;
            vec_q  <= SRC_EXT0;
        end else begin
            if (penult || last) begin
                snap_q <= pend & ~ack_vec;
            end
            take_q <= grant;
            if (grant) begin
                vec_q <= pk.idx;
            end
        end
    end

    assign take = take_q;
    assign vec  = vec_q;

    // R5
    take_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        take_q |-> $past(last));

    // R11
    single_ack_chk: assert property (@(posedge clk) disable iff (rst)
        take_q |=> !take_q);

    // R6
    qualified_chk: assert property (@(posedge clk) disable iff (rst)
        take_q |-> ($past(snap_q) != '0));

    // R9
    global_gate_chk: assert property (@(posedge clk) disable iff (rst)
        take_q |-> $past(gie));

    // R8
    prio_order_chk: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (($past(cand) & (onehot_of(vec_q) - src_vec_t'(1))) == '0));

endmodule

// File: rtl/irq_poll_ctl.sv
module irq_poll_ctl
    import irq_poll_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ext0_n,
    input  logic            ext1_n,
    input  logic            ext0_edge,
    input  logic            ext1_edge,
    input  logic            tmr0_evt,
    input  logic            tmr1_evt,
    input  logic            tmr2_evt,
    input  logic            uart_evt,
    input  logic            spi_evt,
    input  logic [IE_W-1:0] ie_main,
    input  logic [IE_W-1:0] ie_aux,
    input  logic            last_cyc,
    input  logic            penult_cyc,
    output logic            irq_take,
    output logic [VEC_W-1:0] irq_vec
);

    logic [EXT_N-1:0] pin_n;
    logic [EXT_N-1:0] edge_sel;
    logic [EXT_N-1:0] ext_ack;
    logic [EXT_N-1:0] ext_req;
    src_vec_t         raw;
    src_vec_t         pend;
    src_vec_t         en_vec;
    src_vec_t         ack_vec;
    src_e             vec_sel;
    logic             unused_ie;

    assign pin_n    = {ext1_n, ext0_n};
    assign edge_sel = {ext1_edge, ext0_edge};
    assign ext_ack  = {ack_vec[SRC_EXT1], ack_vec[SRC_EXT0]};

    for (genvar k = 0; k < int'(EXT_N); k++) begin : g_ext
        irq_ext_sense u_sense (
            .clk       (clk),
            .rst       (rst),
            .pin_n     (pin_n[k]),
            .edge_mode (edge_sel[k]),
            .ack       (ext_ack[k]),
            .req       (ext_req[k])
        );
    end

    always_comb begin
        raw           = '0;
        raw[SRC_EXT0] = ext_req[0];
        raw[SRC_TMR0] = tmr0_evt;
        raw[SRC_EXT1] = ext_req[1];
        raw[SRC_TMR1] = tmr1_evt;
        raw[SRC_UART] = uart_evt;
        raw[SRC_TMR2] = tmr2_evt;
        raw[SRC_SPI]  = spi_evt;
    end

    irq_latch_bank #(
        .N     (SRC_N),
        .LATCH (LATCHED_SRC)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .raw     (raw),
        .ack_vec (ack_vec),
        .pend    (pend)
    );

    assign en_vec    = build_enables(ie_main, ie_aux);
    assign unused_ie = ^{ie_main[6], ie_aux[7:3], ie_aux[1:0]};

    irq_poll_core u_core (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .en_vec  (en_vec),
        .gie     (ie_main[IE_GLOBAL_BIT]),
        .last    (last_cyc),
        .penult  (penult_cyc),
        .take    (irq_take),
        .vec     (vec_sel),
        .ack_vec (ack_vec)
    );

    assign irq_vec = vec_sel;

endmodule

// File: tb/irq_poll_ctl_bench.sv
module irq_poll_ctl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       ext0_n, ext1_n, ext0_edge, ext1_edge;
    logic       tmr0_evt, tmr1_evt, tmr2_evt, uart_evt, spi_evt;
    logic [7:0] ie_main, ie_aux;
    logic       last_cyc, penult_cyc;
    logic       irq_take;
    logic [2:0] irq_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_poll_ctl u_irq_poll_ctl (
        .clk(clk), .rst(rst),
        .ext0_n(ext0_n), .ext1_n(ext1_n),
        .ext0_edge(ext0_edge), .ext1_edge(ext1_edge),
        .tmr0_evt(tmr0_evt), .tmr1_evt(tmr1_evt), .tmr2_evt(tmr2_evt),
        .uart_evt(uart_evt), .spi_evt(spi_evt),
        .ie_main(ie_main), .ie_aux(ie_aux),
        .last_cyc(last_cyc), .penult_cyc(penult_cyc),
        .irq_take(irq_take), .irq_vec(irq_vec)
    );

    // raise bit n requests vector n (pins via level mode, others via strobe)
    typedef struct packed {
        logic [6:0] raise;
        logic [7:0] iem;
        logic [7:0] iea;
        logic       tk;
        logic [2:0] v;
    } tv_t;

    localparam int NV = 11;
    localparam tv_t TBL [NV] = '{
        {7'h7F, 8'hBF, 8'h04, 1'b1, 3'd0},   // R8 all pending
        {7'h7E, 8'hBF, 8'h04, 1'b1, 3'd1},   // R8
        {7'h7C, 8'hBF, 8'h04, 1'b1, 3'd2},   // R8
        {7'h78, 8'hBF, 8'h04, 1'b1, 3'd3},   // R8
        {7'h70, 8'hBF, 8'h04, 1'b1, 3'd4},   // R8
        {7'h60, 8'hBF, 8'h04, 1'b1, 3'd5},   // R8
        {7'h40, 8'hBF, 8'h04, 1'b1, 3'd6},   // R8
        {7'h7F, 8'h3F, 8'h04, 1'b0, 3'd0},   // R9 global off
        {7'h50, 8'h80, 8'h04, 1'b1, 3'd6},   // R10 serial disabled, SPI enabled
        {7'h12, 8'h92, 8'h00, 1'b1, 3'd1},   // R9 subset enabled
        {7'h7F, 8'h84, 8'h00, 1'b1, 3'd2}    // R9 only ext1 enabled
    };

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic instr(input int n, output logic tk, output logic [2:0] vv);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            penult_cyc = (i == n - 2);
            last_cyc   = (i == n - 1);
        end
        @(negedge clk);
        penult_cyc = 1'b0;
        last_cyc   = 1'b0;
        tk = irq_take;
        vv = irq_vec;
    endtask

    task automatic drain();
        logic tk;
        logic [2:0] vv;
        ie_main = 8'hBF;
        ie_aux  = 8'h04;
        for (int k = 0; k < 10; k++) begin
            instr(2, tk, vv);
            if (!tk) break;
        end
    endtask

    task automatic strobe_all_low();
        tmr0_evt = 1'b0; tmr1_evt = 1'b0; tmr2_evt = 1'b0;
        uart_evt = 1'b0; spi_evt = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R5 watchdog got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic       tk;
        logic [2:0] vv;
        tv_t        e;

        rst = 1'b1;
        ext0_n = 1'b1; ext1_n = 1'b1; ext0_edge = 1'b0; ext1_edge = 1'b0;
        strobe_all_low();
        ie_main = 8'h00; ie_aux = 8'h00;
        last_cyc = 1'b0; penult_cyc = 1'b0;

        repeat (3) @(negedge clk);
        chk(irq_take == 1'b0, "R1 take in reset", int'(irq_take), 0);
        chk(irq_vec == 3'd0, "R1 vec in reset", int'(irq_vec), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(irq_take == 1'b0, "R1 take after reset", int'(irq_take), 0);
        ie_main = 8'hBF; ie_aux = 8'h04;
        instr(2, tk, vv);
        chk(tk == 1'b0, "R1 nothing pending", int'(tk), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            e = TBL[i];
            ie_main  = e.iem;
            ie_aux   = e.iea;
            ext0_n   = !e.raise[0];
            tmr0_evt = e.raise[1];
            ext1_n   = !e.raise[2];
            tmr1_evt = e.raise[3];
            uart_evt = e.raise[4];
            tmr2_evt = e.raise[5];
            spi_evt  = e.raise[6];
            @(negedge clk);
            strobe_all_low();
            instr(2, tk, vv);
            ext0_n = 1'b1;
            ext1_n = 1'b1;
            chk(tk == e.tk, "R8/R9/R10 table take", int'(tk), int'(e.tk));
            if (e.tk)
                chk(vv == e.v, "R8/R9/R10 table vector", int'(vv), int'(e.v));
            drain();
        end

        // R2 R3: one-cycle low pulse on ext0 in edge mode
        ext0_edge = 1'b1;
        repeat (2) @(negedge clk);
        ext0_n = 1'b0;
        @(negedge clk);
        ext0_n = 1'b1;
        instr(2, tk, vv);
        chk(tk == 1'b1 && vv == 3'd0, "R2 pulse sampled", int'({tk, vv}), 8);
        instr(2, tk, vv);
        chk(tk == 1'b0, "R3 edge flag cleared on take", int'(tk), 0);
        ext0_edge = 1'b0;

        // R3 R9: ext1 edge flag held while disabled, cleared after take
        ext1_edge = 1'b1;
        @(negedge clk);
        ext1_n = 1'b0;
        ie_main = 8'h80; ie_aux = 8'h00;
        repeat (2) @(negedge clk);
        instr(2, tk, vv);
        chk(tk == 1'b0, "R9 disabled ext1 not taken", int'(tk), 0);
        ie_main = 8'hBF; ie_aux = 8'h04;
        instr(2, tk, vv);
        chk(tk == 1'b1 && vv == 3'd2, "R3 latched edge taken", int'({tk, vv}), 10);
        instr(2, tk, vv);
        chk(tk == 1'b0, "R3 pin still low, no retake", int'(tk), 0);
        ext1_n = 1'b1;
        ext1_edge = 1'b0;
        @(negedge clk);

        // R12 R2: level request persists while pin low
        ext1_n = 1'b0;
        @(negedge clk);
        instr(2, tk, vv);
        chk(tk == 1'b1 && vv == 3'd2, "R12 level first take", int'({tk, vv}), 10);
        instr(2, tk, vv);
        chk(tk == 1'b1 && vv == 3'd2, "R12 level retaken", int'({tk, vv}), 10);
        ext1_n = 1'b1;
        instr(2, tk, vv);
        chk(tk == 1'b0, "R2 level released", int'(tk), 0);

        // R6 R7: request arriving in the next-to-last cycle
        tmr1_evt = 1'b1;
        penult_cyc = 1'b1;
        @(negedge clk);
        tmr1_evt = 1'b0;
        penult_cyc = 1'b0;
        last_cyc = 1'b1;
        @(negedge clk);
        last_cyc = 1'b0;
        chk(irq_take == 1'b0, "R6 late request not taken", int'(irq_take), 0);
        instr(1, tk, vv);
        chk(tk == 1'b1 && vv == 3'd3, "R7 single-cycle uses prior last", int'({tk, vv}), 11);
        @(negedge clk);
        chk(irq_take == 1'b0, "R5 take lasts one cycle", int'(irq_take), 0);

        // R7: flag set after previous boundary is not seen by a 1-cycle instr
        tmr0_evt = 1'b1;
        @(negedge clk);
        tmr0_evt = 1'b0;
        instr(1, tk, vv);
        chk(tk == 1'b0, "R7 stale snapshot", int'(tk), 0);
        instr(1, tk, vv);
        chk(tk == 1'b1 && vv == 3'd1, "R7 next boundary", int'({tk, vv}), 9);

        // R9 R10: SPI latched while disabled
        ie_aux = 8'h00;
        spi_evt = 1'b1;
        @(negedge clk);
        spi_evt = 1'b0;
        instr(2, tk, vv);
        chk(tk == 1'b0, "R9 SPI disabled", int'(tk), 0);
        ie_aux = 8'h04;
        instr(2, tk, vv);
        chk(tk == 1'b1 && vv == 3'd6, "R10 SPI own vector", int'({tk, vv}), 14);

        // R11: last_cyc held through the acknowledge cycle
        tmr0_evt = 1'b1;
        tmr2_evt = 1'b1;
        @(negedge clk);
        tmr0_evt = 1'b0;
        tmr2_evt = 1'b0;
        penult_cyc = 1'b1;
        @(negedge clk);
        penult_cyc = 1'b0;
        last_cyc = 1'b1;
        @(negedge clk);
        chk(irq_take == 1'b1 && irq_vec == 3'd1, "R11 first take",
            int'({irq_take, irq_vec}), 9);
        @(negedge clk);
        last_cyc = 1'b0;
        chk(irq_take == 1'b0, "R11 no take in ack cycle", int'(irq_take), 0);
        instr(1, tk, vv);
        chk(tk == 1'b1 && vv == 3'd5, "R11 deferred request", int'({tk, vv}), 13);

        // R5: four-cycle instruction
        tmr1_evt = 1'b1;
        @(negedge clk);
        tmr1_evt = 1'b0;
        instr(4, tk, vv);
        chk(tk == 1'b1 && vv == 3'd3, "R5 four-cycle instr", int'({tk, vv}), 11);
        @(negedge clk);
        chk(irq_take == 1'b0, "R5 pulse width", int'(irq_take), 0);
        instr(2, tk, vv);
        chk(tk == 1'b0, "R4 flag cleared on take", int'(tk), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule